// File: doc/BRIEF.md
# Matrix Key Event Filter

This block sits between a keyboard matrix scanner and whatever consumes key events. Once per scan pass the scanner hands it a snapshot: up to eight slots, each carrying a 7-bit scancode and a mask bit that says whether the slot holds a pressed key. The block compares each accepted snapshot with the set it accepted last time. It then emits one event per cycle on a valid/ready channel. Releases come first, for keys that disappeared. Presses follow, for every key in the new set.

Two refinements are applied before the comparison. First, a configurable function key can be taken out of the set. While that key is held, every other code moves into a second bank, 128 codes higher. Second, an optional filter drops any snapshot of three or more keys in which some pair of keys shares a row and some pair shares a column. Such a pattern may be a phantom reading of the matrix, so the snapshot produces nothing and the stored set is left untouched.

A sync pulse marks the end of each burst. The consumer can therefore commit a whole snapshot's worth of changes at once.

Top module: `kbd_event_filter`

## Requirements
- R1: Each slot's scancode is row*8 + column: bits 6:3 hold the row and bits 2:0 the column. Bit i of `snap_mask` marks slot i, which sits at `snap_codes[7*i +: 7]`, as holding a pressed key.
- R2: With `cfg_fn_en` high, a slot whose code equals `cfg_fn_code` is never reported and marks the function key as held. With `cfg_fn_en` low, that code is reported like any other key.
- R3: While the function key is held, every reported code of that snapshot has 128 added, so `ev_code[7]` is 1. Otherwise `ev_code[7]` is 0.
- R4: A snapshot is ghosted when all of these hold: `cfg_ghost_en` is high, at least three keys remain after removal of the function key, some pair of them shares a row, and some pair shares a column. A ghosted snapshot produces no event and no sync, and the stored set stays as it was.
- R5: With the filter disabled, or with fewer than three remaining keys, the row/column pattern has no effect on the events.
- R6: Each key of the stored set that is absent from the new set, comparing all 8 code bits, produces a release event (`ev_pressed`=0). Releases come in ascending stored-slot order, and all of them precede the presses.
- R7: Every key of the new set, including keys that were already held, produces a press event (`ev_pressed`=1). Presses come in ascending slot order.
- R8: A snapshot with no keys releases every stored key and leaves the stored set empty.
- R9: While `ev_valid` is high and `ev_ready` is low, `ev_code` and `ev_pressed` hold their values. `snap_ready` stays low until the burst has drained.
- R10: `ev_sync` is high together with the last event of a burst. An accepted, non-ghosted snapshot that yields no events instead raises `ev_sync` alone, with `ev_valid` low, for the single cycle after acceptance.
- R11: After reset there is no pending event, no sync, the stored set is empty and `snap_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_fn_en | input | 1 | Enables function-key removal and bank shift |
| cfg_fn_code | input | 7 | Scancode of the function key |
| cfg_ghost_en | input | 1 | Enables the ghost filter |
| snap_valid | input | 1 | Snapshot offered |
| snap_ready | output | 1 | Snapshot can be taken |
| snap_mask | input | 8 | Per-slot key-present bits |
| snap_codes | input | 56 | Eight 7-bit scancodes, slot i at bits 7*i+6:7*i |
| ev_valid | output | 1 | Event present |
| ev_ready | input | 1 | Consumer takes the event |
| ev_code | output | 8 | Event code, bit 7 is the alternate bank |
| ev_pressed | output | 1 | 1 for press, 0 for release |
| ev_sync | output | 1 | End of burst |

## Verification
A snapshot is taken on the clock edge where `snap_valid` and `snap_ready` are both high. The first event, or the standalone sync, is already on the outputs just after that edge, so the bench samples it at the next falling edge. Each later event appears one edge after the previous one was taken, and `snap_ready` returns one edge after the last event or sync. Inputs are driven and outputs are sampled on falling edges only, so the bench reads each result in the cycle it is due. During a stall it reads the held event once per cycle.

// File: rtl/kbd_event_filter.sv
module kbd_event_filter #(
  parameter int NENT = 8,
  parameter int RW   = 4,
  parameter int CW   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_fn_en,
  input  logic [RW+CW-1:0]    cfg_fn_code,
  input  logic                cfg_ghost_en,
  input  logic                snap_valid,
  output logic                snap_ready,
  input  logic [NENT-1:0]     snap_mask,
  input  logic [NENT*(RW+CW)-1:0] snap_codes,
  output logic                ev_valid,
  input  logic                ev_ready,
  output logic [RW+CW:0]      ev_code,
  output logic                ev_pressed,
  output logic                ev_sync
);
  localparam int SW = RW + CW;
  localparam int EW = SW + 1;
  localparam int IW = (NENT > 1) ? $clog2(NENT) : 1;

  logic [NENT-1:0][EW-1:0] cur_code, old_code, new_code;
  logic [NENT-1:0] cur_mask, keep, rel_new, rel_pend, prs_pend;
  logic fn_held, row_hit, col_hit, ghosted, quiet_sync, busy, use_rel, accept;
  logic [IW-1:0] rel_idx, prs_idx;

  always_comb begin
    fn_held = 1'b0;
    for (int i = 0; i < NENT; i++) begin
      logic [SW-1:0] raw;
      raw = snap_codes[i*SW +: SW];
      keep[i] = snap_mask[i];
      if (snap_mask[i] && cfg_fn_en && raw == cfg_fn_code) begin
        keep[i] = 1'b0;
        fn_held = 1'b1;
      end
    end
    for (int i = 0; i < NENT; i++)
      new_code[i] = {fn_held, snap_codes[i*SW +: SW]};
  end

  always_comb begin
    row_hit = 1'b0;
    col_hit = 1'b0;
    for (int i = 0; i < NENT; i++)
      for (int j = i + 1; j < NENT; j++)
        if (keep[i] && keep[j]) begin
          if (new_code[i][SW-1:CW] == new_code[j][SW-1:CW]) row_hit = 1'b1;
          if (new_code[i][CW-1:0] == new_code[j][CW-1:0]) col_hit = 1'b1;
        end
  end

  assign ghosted = cfg_ghost_en && ($countones(keep) >= 3) && row_hit && col_hit;

  always_comb begin
    for (int i = 0; i < NENT; i++) begin
      rel_new[i] = cur_mask[i];
      for (int j = 0; j < NENT; j++)
        if (keep[j] && new_code[j] == cur_code[i]) rel_new[i] = 1'b0;
    end
  end

  always_comb begin
    rel_idx = '0;
    prs_idx = '0;
    for (int i = NENT - 1; i >= 0; i--) begin
      if (rel_pend[i]) rel_idx = IW'(i);
      if (prs_pend[i]) prs_idx = IW'(i);
    end
  end

  assign busy       = |rel_pend || |prs_pend;
  assign use_rel    = |rel_pend;
  assign snap_ready = !busy && !quiet_sync;
  assign accept     = snap_valid && snap_ready;
  assign ev_valid   = busy;
  assign ev_code    = use_rel ? old_code[rel_idx] : cur_code[prs_idx];
  assign ev_pressed = !use_rel;
  assign ev_sync    = (busy && $countones({rel_pend, prs_pend}) == 1) || quiet_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_code   <= '0;
      old_code   <= '0;
      cur_mask   <= '0;
      rel_pend   <= '0;
      prs_pend   <= '0;
      quiet_sync <= 1'b0;
    end else begin
      quiet_sync <= 1'b0;
      if (accept && !ghosted) begin
        old_code   <= cur_code;
        cur_code   <= new_code;
        cur_mask   <= keep;
        rel_pend   <= rel_new;
        prs_pend   <= keep;
        quiet_sync <= !(|rel_new) && !(|keep);
      end else if (ev_valid && ev_ready) begin
        if (use_rel) rel_pend[rel_idx] <= 1'b0;
        else         prs_pend[prs_idx] <= 1'b0;
      end
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && !ev_ready |=> ev_valid && $stable(ev_code) && $stable(ev_pressed));

  p_busy_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && !ev_ready |=> !snap_ready);

  p_release_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_ready && ev_pressed |=> !(ev_valid && !ev_pressed));

  p_sync_ends_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_ready && ev_sync |=> !ev_valid);

  p_ghost_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept && ghosted |=> !ev_valid && !ev_sync && snap_ready);

  p_bank_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !ghosted && |keep && !fn_held |=> ev_valid && (ev_pressed || !ev_code[SW] || |old_code) && !(ev_pressed && ev_code[SW]));
endmodule

// File: tb/kbd_event_filter_test.sv
module kbd_event_filter_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_fn_en = 1'b1, cfg_ghost_en = 1'b1;
  logic [6:0] cfg_fn_code = 7'h7F;
  logic snap_valid = 1'b0, ev_ready = 1'b1;
  logic [7:0] snap_mask = '0;
  logic [55:0] snap_codes = '0;
  logic snap_ready, ev_valid, ev_pressed, ev_sync;
  logic [7:0] ev_code;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  kbd_event_filter uut (
    .clk(clk), .rst_n(rst_n), .cfg_fn_en(cfg_fn_en), .cfg_fn_code(cfg_fn_code),
    .cfg_ghost_en(cfg_ghost_en), .snap_valid(snap_valid), .snap_ready(snap_ready),
    .snap_mask(snap_mask), .snap_codes(snap_codes), .ev_valid(ev_valid),
    .ev_ready(ev_ready), .ev_code(ev_code), .ev_pressed(ev_pressed), .ev_sync(ev_sync));

  typedef struct packed {
    logic [7:0]  mask;
    logic [55:0] keys;
    logic        fn;
    logic        gh;
    logic        ghost;
    logic [3:0]  n;
    logic [53:0] ev;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{8'h03, {7'h11, 7'h22, 42'h0}, 1'b1, 1'b1, 1'b0, 4'd2, {9'h111, 9'h122, 36'h0}},
    '{8'h03, {7'h22, 7'h33, 42'h0}, 1'b1, 1'b1, 1'b0, 4'd3, {9'h011, 9'h122, 9'h133, 27'h0}},
    '{8'h07, {7'h08, 7'h09, 7'h10, 35'h0}, 1'b1, 1'b1, 1'b1, 4'd0, 54'h0},
    '{8'h07, {7'h22, 7'h33, 7'h44, 35'h0}, 1'b1, 1'b1, 1'b0, 4'd3, {9'h122, 9'h133, 9'h144, 27'h0}},
    '{8'h03, {7'h7F, 7'h22, 42'h0}, 1'b1, 1'b1, 1'b0, 4'd4, {9'h022, 9'h033, 9'h044, 9'h1A2, 18'h0}},
    '{8'h07, {7'h08, 7'h7F, 7'h09, 35'h0}, 1'b1, 1'b1, 1'b0, 4'd3, {9'h0A2, 9'h188, 9'h189, 27'h0}},
    '{8'h00, 56'h0, 1'b1, 1'b1, 1'b0, 4'd2, {9'h088, 9'h089, 36'h0}},
    '{8'h00, 56'h0, 1'b1, 1'b1, 1'b0, 4'd0, 54'h0}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic run(input vec_t v, input bit stall, input string tag);
    int got = 0;
    bit first = 1, stalled = 0, fin = 0;
    @(negedge clk);
    cfg_fn_en = v.fn;
    cfg_ghost_en = v.gh;
    snap_mask = v.mask;
    for (int i = 0; i < 8; i++) snap_codes[7*i +: 7] = v.keys[55-7*i -: 7];
    snap_valid = 1'b1;
    chk(snap_ready == 1'b1, {tag, " R9 ready before accept"}, snap_ready, 1);
    @(negedge clk);
    snap_valid = 1'b0;
    for (int t = 0; t < 40 && !fin; t++) begin
      if (t > 0) @(negedge clk);
      if (ev_valid) begin
        logic [8:0] e;
        e = (got < 6) ? v.ev[53-9*got -: 9] : 9'h0;
        if (stall && !stalled) begin
          stalled = 1;
          ev_ready = 1'b0;
          for (int s = 0; s < 3; s++) begin
            @(negedge clk);
            chk(ev_valid && {ev_pressed, ev_code} == e && !snap_ready,
                {tag, " R9 stall hold"}, {ev_valid, snap_ready, ev_pressed, ev_code}, {2'b10, e});
          end
          ev_ready = 1'b1;
        end
        chk({ev_pressed, ev_code} == e, {tag, " R6 R7 event"}, {ev_pressed, ev_code}, e);
        chk(ev_sync == (got == int'(v.n) - 1), {tag, " R10 sync on last"}, ev_sync, got == int'(v.n) - 1);
        got++;
      end else begin
        chk(ev_sync == (first && v.n == 0 && !v.ghost), {tag, " R10 R4 lone sync"},
            ev_sync, first && v.n == 0 && !v.ghost);
        if (snap_ready) fin = 1;
      end
      first = 0;
    end
    chk(got == int'(v.n) && fin, {tag, " R8 event count"}, got, v.n);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(snap_ready && !ev_valid && !ev_sync, "R11 reset state", {snap_ready, ev_valid, ev_sync}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(snap_ready && !ev_valid && !ev_sync, "R11 after release", {snap_ready, ev_valid, ev_sync}, 3'b100);
    // R1 codes, R2 Fn removal, R3 bank, R4 ghost, R5 below three keys, R6..R8 set difference
    for (int k = 0; k < 8; k++) run(VECS[k], 1'b0, $sformatf("vec%0d", k));
    // R5: ghost filter off lets the pattern through
    run('{8'h07, {7'h08, 7'h09, 7'h10, 35'h0}, 1'b0, 1'b0, 1'b0, 4'd3,
          {9'h108, 9'h109, 9'h110, 27'h0}}, 1'b0, "R5 filter off");
    // R2: Fn mode off reports the Fn code; R9: stalled consumer
    run('{8'h01, {7'h7F, 49'h0}, 1'b0, 1'b1, 1'b0, 4'd4,
          {9'h008, 9'h009, 9'h010, 9'h17F, 18'h0}}, 1'b1, "R2 fn off");
    // R8: empty after that clears everything
    run('{8'h00, 56'h0, 1'b1, 1'b1, 1'b0, 4'd1, {9'h07F, 45'h0}}, 1'b0, "R8 clear");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule